// File: doc/BRIEF.md
# Oscillator Stabilization Wait Gate

This block stands between the digitized output of a free-running oscillator and the system clock tree. An oscillator that has just been switched on produces an unstable waveform for a while. The block therefore holds its clock output low until a chosen number of oscillator cycles has passed since oscillation was enabled. Only then does it let the clock through and raise a ready flag.

The wait length comes from a 2-bit select register that is written on the oscillator clock. The highest code gives the shortest wait, and after reset the register holds the longest wait. The enable and sleep controls arrive asynchronously and pass through a two-flop synchronizer first. Dropping the enable or entering sleep clears the flag, closes the gate and restarts the count from zero. The output passes through a latch-based gate that changes state only while the oscillator clock is low, so every pulse that reaches the output has full width.

Top module: `osc_wait_gate`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 0, `gclk_out` is low and the stored wait code is 0. With no write to the select register, the first enable therefore waits 64 cycles.
- R2: With `BASE_WAIT` = 8, stored code 3 gives 8 cycles, code 2 gives 16, code 1 gives 32 and code 0 gives 64. The input is driven between edges. `ready` then rises on oscillator rising edge 2+N counted from the enable change, where the 2 edges are spent in the synchronizer.
- R3: While the wait is running, `gclk_out` shows no rising edge at all.
- R4: Once `ready` has risen, `gclk_out` copies every following oscillator pulse at its full high width. The first copied pulse starts on the edge after `ready` rises.
- R5: `ready` stays at 1 for as long as enable is held and sleep is not requested.
- R6: Clearing `osc_en` drops `ready` on rising edge 3 after the change. `gclk_out` shows no pulse from edge 4 onward. A later enable runs the full wait again from zero.
- R7: Setting `sleep_req` has the same effect as clearing the enable. After sleep is released, the whole selected wait runs again, even if a count had been partly done before sleep.
- R8: A new select code takes part in the comparison on the edge after it is stored. If the count has already reached the new threshold, `ready` rises on that edge. A longer code written mid-wait extends the wait to the new length.
- R9: The select register loads `cfg_sel` only on an edge where `cfg_we` is 1. A value on `cfg_sel` while `cfg_we` is 0 does not change the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Digitized oscillator clock, the clock being gated |
| rst_n | input | 1 | Synchronous active-low reset in the `osc_clk` domain |
| osc_en | input | 1 | Oscillation enable, asynchronous |
| sleep_req | input | 1 | 1 = sleep, 0 = normal; asynchronous |
| cfg_we | input | 1 | Write strobe for the wait select register |
| cfg_sel | input | 2 | Wait code to store: 3 is shortest, 0 is longest |
| gclk_out | output | 1 | Gated clock toward the system clock tree |
| ready | output | 1 | 1 once the wait has elapsed and the gate is open |

## Verification
The hardest case to reach is a select code that changes while a count is already partway through. The stimulus enables the oscillator with the longest code and lets the count run to about twenty. It then writes the shortest code, so `ready` must rise on the very edge after the store and not one cycle earlier. The mirror case writes a longer code a few cycles into a short wait. The bench then checks that `ready` is still low on the edge where the old short wait would have ended. A sleep request placed in the middle of a partial count shows that waking up restarts the full wait and does not resume the old count.

// File: rtl/owg_pkg.sv
// Package: shared definitions for the oscillator stabilization wait gate.
// Assumes wait lengths are a base count scaled by powers of two, with
// the highest code giving the shortest wait.
package owg_pkg;

    // Wait select codes, named by their relative length.
    typedef enum logic [1:0] {
        WAIT_LONGEST  = 2'd0,
        WAIT_LONG     = 2'd1,
        WAIT_SHORT    = 2'd2,
        WAIT_SHORTEST = 2'd3
    } wait_code_e;

    // Number of doublings from the shortest wait to the longest.
    localparam int unsigned WAIT_STEPS = 3;

    // Index of the two bits carried through the synchronizer.
    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_SLEEP = 1;
    localparam int unsigned CTL_W     = 2;

endpackage

// File: rtl/owg_sync.sv
// Module: owg_sync
// Multi-bit synchronizer made of a chain of STAGES flops per bit.
// Assumes the bits are independent levels that change rarely, so they
// need no coherency between bits. Reset clears the chain
// synchronously to zero.
module owg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the asynchronous inputs in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: pass the value down one more stage to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/owg_wait_counter.sv
// Module: owg_wait_counter
// Counts oscillator cycles while `active` is high and raises `ready`
// once the count reaches the threshold for the current wait code.
// The code is read live, so a change takes part in the next
// comparison. Assumes thresholds never exceed BASE_WAIT << WAIT_STEPS,
// so the count cannot wrap. Losing `active` clears everything.
module owg_wait_counter
    import owg_pkg::*;
#(
    parameter int unsigned BASE_WAIT = 8,
    parameter int unsigned CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  wait_code_e       code,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] thr,
    output logic             ready
);

    localparam logic [CNT_W-1:0] BASE_W = CNT_W'(BASE_WAIT);

    logic [CNT_W-1:0] cnt_inc;
    logic [1:0]       shift_amt;
    logic             reach;

    // Purpose: turn the wait code into a cycle threshold (higher code, shorter wait).
    always_comb begin
        shift_amt = 2'(WAIT_STEPS) - code;
        thr       = BASE_W << shift_amt;
    end

    // Purpose: form the next count and test it against the threshold.
    always_comb begin
        cnt_inc = cnt + CNT_W'(1);
        reach   = (cnt_inc >= thr);
    end

    // Purpose: advance the count while waiting; clear it whenever the oscillator is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            cnt   <= cnt_inc;
            ready <= reach;
        end
    end

endmodule

// File: rtl/owg_clock_gate.sv
// Module: owg_clock_gate
// Latch-based glitch-free clock gate. The enable is captured only while
// the incoming clock is low, so the output never starts or ends a pulse
// in the middle of a high phase. Reset forces the latched enable low.
module owg_clock_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic gate_en,
    output logic clk_out
);

    logic en_lat;

    // Purpose: hold the enable steady across each high phase of the clock.
    always_latch begin
        if (!clk_in) en_lat = gate_en & rst_n;
    end

    assign clk_out = clk_in & en_lat;

endmodule

// File: rtl/osc_wait_gate.sv
// Module: osc_wait_gate (top)
// Withholds a free-running oscillator clock from the system until a
// selectable stabilization wait has elapsed after oscillation is
// enabled. Everything runs on the oscillator clock itself. Assumes
// that clock toggles whenever counting is expected and that
// `rst_n` is applied for at least one of its edges. The enable and sleep
// inputs are asynchronous. The select register is written on osc_clk.
module osc_wait_gate
    import owg_pkg::*;
#(
    parameter int unsigned BASE_WAIT   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       sleep_req,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    output logic       gclk_out,
    output logic       ready
);

    localparam int unsigned MAX_WAIT = BASE_WAIT << WAIT_STEPS;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

    logic [CTL_W-1:0] ctl_async;
    logic [CTL_W-1:0] ctl_sync;
    logic             active;
    wait_code_e       sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;

    // Purpose: gather the asynchronous controls into one synchronizer word.
    always_comb begin
        ctl_async            = '0;
        ctl_async[CTL_EN]    = osc_en;
        ctl_async[CTL_SLEEP] = sleep_req;
    end

    owg_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .async_in (ctl_async),
        .sync_out (ctl_sync)
    );

    // Purpose: the oscillator counts only when enabled and not asleep.
    assign active = ctl_sync[CTL_EN] & ~ctl_sync[CTL_SLEEP];

    // Purpose: wait select register, reset to the longest wait.
    always_ff @(posedge osc_clk) begin
        if (!rst_n)      sel_q <= WAIT_LONGEST;
        else if (cfg_we) sel_q <= wait_code_e'(cfg_sel);
    end

    owg_wait_counter #(
        .BASE_WAIT (BASE_WAIT),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .active (active),
        .code   (sel_q),
        .cnt    (cnt),
        .thr    (thr),
        .ready  (ready)
    );

    owg_clock_gate u_gate (
        .clk_in  (osc_clk),
        .rst_n   (rst_n),
        .gate_en (ready),
        .clk_out (gclk_out)
    );

endmodule

// File: rtl/owg_checker.sv
// Module: owg_checker
// Property checks for osc_wait_gate, attached with a bind. The gate
// checks are clocked on the falling edge, so the sampled gclk value
// is the one from the high phase that just ended.
module owg_checker #(
    parameter int unsigned CNT_W = 7
) (
    input logic             osc_clk,
    input logic             rst_n,
    input logic             active,
    input logic             ready,
    input logic             gclk_out,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr
);

    // R3: gate stays closed through any high phase that follows a low ready
    assert_gate_closed_R3: assert property (@(negedge osc_clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> !gclk_out);

    // R4: gate passes every high phase once ready has settled
    assert_gate_open_R4: assert property (@(negedge osc_clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> gclk_out);

    // R5: ready holds while the oscillator remains active
    assert_ready_hold_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (ready && active) |=> ready);

    // R6: loss of activity clears ready and the count on the next edge
    assert_clear_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !active |=> (!ready && cnt == '0));

    // R2: ready never rises before the count meets the threshold
    assert_no_early_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (active && !ready && (cnt + 1'b1 < thr)) |=> !ready);

    // R8: ready rises as soon as the count can meet the threshold
    assert_prompt_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (active && !ready && (cnt + 1'b1 >= thr)) |=> ready);

endmodule

bind osc_wait_gate owg_checker #(.CNT_W(CNT_W)) u_owg_checker (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .active   (active),
    .ready    (ready),
    .gclk_out (gclk_out),
    .cnt      (cnt),
    .thr      (thr)
);

// File: tb/osc_wait_gate_test.sv
`timescale 1ns/1ps
// Directed bench for osc_wait_gate: one task per scenario.
module osc_wait_gate_test;

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       sleep_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic       gclk_out;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    int gpulses = 0;
    int bad_width = 0;
    realtime t_rise = 0.0;

    osc_wait_gate uut (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .sleep_req (sleep_req),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .gclk_out  (gclk_out),
        .ready     (ready)
    );

    always #5 osc_clk = ~osc_clk;

    always @(posedge gclk_out) begin
        gpulses++;
        t_rise = $realtime;
    end

    always @(negedge gclk_out) begin
        if (t_rise > 0.0 && ($realtime - t_rise) != 5.0) bad_width++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic write_sel(input logic [1:0] code);
        cfg_we  = 1'b1;
        cfg_sel = code;
        @(negedge osc_clk);
        cfg_we  = 1'b0;
    endtask

    // Enable, count edges up to ready, then check gate behaviour (R3, R4, R5).
    task automatic measure_wait(input int exp, input string req);
        int n = 0;
        gpulses = 0;
        osc_en  = 1'b1;
        while (!ready && n < 300) begin
            @(negedge osc_clk);
            n++;
        end
        chk(req, n, exp);
        chk("R3 no pulse during wait", gpulses, 0);
        gpulses = 0;
        repeat (10) @(negedge osc_clk);
        chk("R4 pulses after ready", gpulses, 10);
        chk("R5 ready held", int'(ready), 1);
    endtask

    // Drop the enable and check the clear timing (R6).
    task automatic disable_osc();
        osc_en = 1'b0;
        repeat (2) @(negedge osc_clk);
        chk("R6 ready still set at edge 2", int'(ready), 1);
        @(negedge osc_clk);
        chk("R6 ready cleared at edge 3", int'(ready), 0);
        gpulses = 0;
        repeat (6) @(negedge osc_clk);
        chk("R6 no pulse after disable", gpulses, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge osc_clk);
        chk("R1 ready in reset", int'(ready), 0);
        chk("R1 gclk in reset", int'(gclk_out), 0);
        rst_n = 1'b1;
        @(negedge osc_clk);
        measure_wait(66, "R1 default 64-cycle wait");
        disable_osc();
    endtask

    task automatic t_codes();
        for (int c = 3; c >= 0; c--) begin
            write_sel(2'(c));
            measure_wait((8 << (3 - c)) + 2, $sformatf("R2 code %0d wait", c));
            disable_osc();
        end
    endtask

    task automatic t_disable_restart();
        write_sel(2'd2);
        osc_en = 1'b1;
        repeat (12) @(negedge osc_clk);
        osc_en = 1'b0;
        repeat (5) @(negedge osc_clk);
        chk("R6 not ready after partial wait", int'(ready), 0);
        measure_wait(18, "R6 restart full wait");
        disable_osc();
    endtask

    task automatic t_sleep();
        write_sel(2'd3);
        measure_wait(10, "R7 wait before sleep");
        sleep_req = 1'b1;
        repeat (2) @(negedge osc_clk);
        chk("R7 ready before sleep takes hold", int'(ready), 1);
        @(negedge osc_clk);
        chk("R7 sleep clears ready", int'(ready), 0);
        gpulses = 0;
        repeat (6) @(negedge osc_clk);
        chk("R7 no pulse in sleep", gpulses, 0);
        write_sel(2'd2);
        sleep_req = 1'b0;
        repeat (12) @(negedge osc_clk);
        sleep_req = 1'b1;
        repeat (5) @(negedge osc_clk);
        chk("R7 not ready in sleep", int'(ready), 0);
        sleep_req = 1'b0;
        measure_wait(18, "R7 full wait after wake");
        disable_osc();
    endtask

    task automatic t_ignore_bus();
        write_sel(2'd2);
        cfg_sel = 2'd3;
        measure_wait(18, "R9 unwritten select ignored");
        disable_osc();
    endtask

    task automatic t_shorten();
        write_sel(2'd0);
        osc_en = 1'b1;
        repeat (22) @(negedge osc_clk);
        cfg_we  = 1'b1;
        cfg_sel = 2'd3;
        @(negedge osc_clk);
        cfg_we  = 1'b0;
        chk("R8 not ready on store edge", int'(ready), 0);
        @(negedge osc_clk);
        chk("R8 ready on edge after store", int'(ready), 1);
        disable_osc();
    endtask

    task automatic t_lengthen();
        write_sel(2'd3);
        osc_en = 1'b1;
        repeat (4) @(negedge osc_clk);
        cfg_we  = 1'b1;
        cfg_sel = 2'd1;
        @(negedge osc_clk);
        cfg_we  = 1'b0;
        repeat (5) @(negedge osc_clk);
        chk("R8 old short wait no longer applies", int'(ready), 0);
        repeat (23) @(negedge osc_clk);
        chk("R8 not ready at edge 33", int'(ready), 0);
        @(negedge osc_clk);
        chk("R8 ready at edge 34", int'(ready), 1);
        disable_osc();
    endtask

    initial begin
        @(negedge osc_clk);
        t_reset();
        t_codes();
        t_disable_restart();
        t_sleep();
        t_ignore_bus();
        t_shorten();
        t_lengthen();
        chk("R4 full-width output pulses", bad_width, 0);
        summary();
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule